// File: doc/BRIEF.md
# Real-Mode Storage Attribute Unit

This unit keeps four per-region attribute planes and one store-fault enable bit, and it resolves the attributes of every memory access presented to it. The planes are guard, user-defined, byte order and cache-inhibit. The address space is split into equal regions, and the top address bits name the region. When address translation is off (real mode), the region's bit is read from each plane. When translation is on (virtual mode), the planes are bypassed and the attributes delivered with the translation entry are used instead.

From the resolved attributes the unit gives one verdict per access: grant, stall or deny. Speculative reads and prefetches into guarded space are refused. A demand instruction fetch from guarded space is held until the core reports that all earlier instructions are complete. A store into user-flagged space is refused when the fault enable is set, and the unit then raises a data-storage fault with a cause code one cycle later. The selected byte order is driven out for the load/store datapath.

Top module: `rmattr_unit`

## Requirements
- R1: After reset every plane bit and the fault enable are 0. Any access then reads guard 0, user 0, cache-inhibit 0, byte order big-endian (`byte_le` 0) and is granted, with no fault.
- R2: The region index is `acc_addr[31:27]`. Plane bit k covers addresses k*0x0800_0000 through k*0x0800_0000+0x07FF_FFFF, so the first byte of the next region reads bit k+1.
- R3: In real mode (`acc_virt` 0), `out_guard`, `out_user`, `byte_le` and `out_nocache` equal bit k of the guard, user, order and cache-inhibit planes. The planes are written through `cfg_wr_sel` 0, 1, 2 and 3, and `cfg_wr_sel` 4 writes the fault enable from `cfg_wr_data[0]`.
- R4: In virtual mode (`acc_virt` 1), the resolved attributes equal `tlb_guard`, `tlb_user`, `tlb_little` and `tlb_nocache`, whatever the planes hold.
- R5: An access is speculative when `acc_spec` is 1 or when `acc_kind` is prefetch (3). A speculative access to a guarded region is denied. A speculative access to an unguarded region, or a non-speculative load (1) to a guarded one, is granted.
- R6: A non-speculative fetch (`acc_kind` 0) to a guarded region raises `acc_stall` in every cycle in which `prior_done` is 0. It is granted in the first cycle in which `prior_done` is 1.
- R7: A store (`acc_kind` 2) to a user-flagged region while the fault enable is 1 is denied. In the following cycle `dsi_valid` is 1 for exactly that cycle per store, with `dsi_cause` = 1.
- R8: With the fault enable at 0, a store to a user-flagged region is granted and raises no fault. Fetches and loads never fault, whatever the user attribute.
- R9: `byte_le` is 0 (big-endian) when the resolved order attribute is 0, and 1 (little-endian) when it is 1.
- R10: A register write lands at the clock edge. An access in the same cycle as the write sees the old value, and an access in the next cycle sees the new one.
- R11: While `acc_valid` is 1, exactly one of `acc_grant`, `acc_stall`, `acc_deny` is 1. While it is 0, all three are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 3 | Target: 0 guard, 1 user, 2 order, 3 cache-inhibit, 4 fault enable |
| cfg_wr_data | input | 32 | Plane value, or fault enable in bit 0 |
| acc_valid | input | 1 | Access presented this cycle |
| acc_addr | input | 32 | Effective address |
| acc_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 prefetch |
| acc_spec | input | 1 | Access is speculative |
| acc_virt | input | 1 | Translation on (take attributes from the TLB inputs) |
| tlb_guard | input | 1 | Guard attribute from the translation entry |
| tlb_user | input | 1 | User attribute from the translation entry |
| tlb_little | input | 1 | Byte-order attribute from the translation entry |
| tlb_nocache | input | 1 | Cache-inhibit attribute from the translation entry |
| prior_done | input | 1 | All earlier instructions have completed |
| out_guard | output | 1 | Resolved guard attribute |
| out_user | output | 1 | Resolved user attribute |
| out_nocache | output | 1 | Resolved cache-inhibit attribute |
| byte_le | output | 1 | Selected byte order, 1 = little-endian |
| acc_grant | output | 1 | Access may proceed |
| acc_stall | output | 1 | Guarded fetch waiting for completion |
| acc_deny | output | 1 | Access refused |
| dsi_valid | output | 1 | Data-storage fault pulse, one cycle after the store |
| dsi_cause | output | 2 | Fault cause, 1 = store to user-flagged region |

## Verification
A register write and an access can fall in the same cycle. The bench provokes this by writing the guard plane in the same step as a speculative load to the region it changes, then repeating the load in the next step. The first load must be granted on the old value and the second denied. A store fault also overlaps the next access: the bench issues stores back to back, and follows a store with a load. The one-cycle-late `dsi_valid` pulse is then checked in the same cycle as the next access's verdict, and each pulse must belong to the earlier store alone.

// File: rtl/rmattr_pkg.sv
package rmattr_pkg;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_PREF  = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        SEL_GUARD   = 3'd0,
        SEL_USER    = 3'd1,
        SEL_ORDER   = 3'd2,
        SEL_NOCACHE = 3'd3,
        SEL_CTRL    = 3'd4
    } wsel_e;

    localparam int unsigned NPLANE = 4;

    typedef enum logic [1:0] {
        CAUSE_NONE       = 2'd0,
        CAUSE_USER_STORE = 2'd1
    } cause_e;

    typedef struct packed {
        logic guard;
        logic user;
        logic little;
        logic nocache;
    } attr_t;

    typedef struct packed {
        logic grant;
        logic stall;
        logic deny;
        logic fault;
    } verdict_t;

    function automatic logic is_speculative(acc_kind_e kind, logic spec);
        return spec || (kind == ACC_PREF);
    endfunction

endpackage

// File: rtl/rmattr_regs.sv
module rmattr_regs
    import rmattr_pkg::*;
#(
    parameter int unsigned REGION_BITS = 5,
    localparam int unsigned NREG = 1 << REGION_BITS
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [2:0]                    wr_sel,
    input  logic [NREG-1:0]               wr_data,
    output logic [NPLANE-1:0][NREG-1:0]   planes,
    output logic                          user_exc_en
);

    // One register per attribute plane, selected by its write code.
    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        always_ff @(posedge clk) begin
            if (rst) begin
                planes[p] <= '0;
            end else if (wr_en && (wr_sel == 3'(p))) begin
                planes[p] <= wr_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            user_exc_en <= 1'b0;
        end else if (wr_en && (wsel_e'(wr_sel) == SEL_CTRL)) begin
            user_exc_en <= wr_data[0];
        end
    end

endmodule

// File: rtl/rmattr_select.sv
module rmattr_select
    import rmattr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned REGION_BITS = 5,
    localparam int unsigned NREG = 1 << REGION_BITS
) (
    input  logic [NPLANE-1:0][NREG-1:0] planes,
    input  logic [ADDR_W-1:0]           addr,
    input  logic                        virt,
    input  attr_t                       tlb_attr,
    output attr_t                       attr
);

    logic [REGION_BITS-1:0] region;
    logic [NPLANE-1:0]      bits;
    attr_t                  real_attr;

    assign region = addr[ADDR_W-1 -: REGION_BITS];

    for (genvar p = 0; p < NPLANE; p++) begin : g_pick
        assign bits[p] = planes[p][region];
    end

    always_comb begin
        real_attr         = '0;
        real_attr.guard   = bits[SEL_GUARD];
        real_attr.user    = bits[SEL_USER];
        real_attr.little  = bits[SEL_ORDER];
        real_attr.nocache = bits[SEL_NOCACHE];
        attr = virt ? tlb_attr : real_attr;
    end

endmodule

// File: rtl/rmattr_gate.sv
module rmattr_gate
    import rmattr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      valid,
    input  acc_kind_e kind,
    input  logic      spec,
    input  attr_t     attr,
    input  logic      prior_done,
    input  logic      user_exc_en,
    output verdict_t  verdict,
    output logic      fault_q,
    output cause_e    cause_q
);

    always_comb begin
        verdict = '0;
        if (valid) begin
            if (attr.guard && is_speculative(kind, spec)) begin
                verdict.deny = 1'b1;
            end else if ((kind == ACC_FETCH) && attr.guard && !prior_done) begin
                verdict.stall = 1'b1;
            end else if ((kind == ACC_STORE) && attr.user && user_exc_en) begin
                verdict.deny  = 1'b1;
                verdict.fault = 1'b1;
            end else begin
                verdict.grant = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
        end else begin
            fault_q <= verdict.fault;
            cause_q <= verdict.fault ? CAUSE_USER_STORE : CAUSE_NONE;
        end
    end

endmodule

// File: rtl/rmattr_unit.sv
module rmattr_unit
    import rmattr_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned REGION_BITS = 5,
    localparam int unsigned NREG = 1 << REGION_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_en,
    input  logic [2:0]        cfg_wr_sel,
    input  logic [NREG-1:0]   cfg_wr_data,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_spec,
    input  logic              acc_virt,
    input  logic              tlb_guard,
    input  logic              tlb_user,
    input  logic              tlb_little,
    input  logic              tlb_nocache,
    input  logic              prior_done,
    output logic              out_guard,
    output logic              out_user,
    output logic              out_nocache,
    output logic              byte_le,
    output logic              acc_grant,
    output logic              acc_stall,
    output logic              acc_deny,
    output logic              dsi_valid,
    output logic [1:0]        dsi_cause
);

    logic [NPLANE-1:0][NREG-1:0] planes;
    logic                        user_exc_en;
    attr_t                       tlb_attr;
    attr_t                       attr;
    verdict_t                    verdict;
    cause_e                      cause_q;

    always_comb begin
        tlb_attr         = '0;
        tlb_attr.guard   = tlb_guard;
        tlb_attr.user    = tlb_user;
        tlb_attr.little  = tlb_little;
        tlb_attr.nocache = tlb_nocache;
    end

    rmattr_regs #(.REGION_BITS(REGION_BITS)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (cfg_wr_en),
        .wr_sel      (cfg_wr_sel),
        .wr_data     (cfg_wr_data),
        .planes      (planes),
        .user_exc_en (user_exc_en)
    );

    rmattr_select #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) u_sel (
        .planes   (planes),
        .addr     (acc_addr),
        .virt     (acc_virt),
        .tlb_attr (tlb_attr),
        .attr     (attr)
    );

    rmattr_gate u_gate (
        .clk         (clk),
        .rst         (rst),
        .valid       (acc_valid),
        .kind        (acc_kind_e'(acc_kind)),
        .spec        (acc_spec),
        .attr        (attr),
        .prior_done  (prior_done),
        .user_exc_en (user_exc_en),
        .verdict     (verdict),
        .fault_q     (dsi_valid),
        .cause_q     (cause_q)
    );

    assign out_guard   = attr.guard;
    assign out_user    = attr.user;
    assign out_nocache = attr.nocache;
    assign byte_le     = attr.little;
    assign acc_grant   = verdict.grant;
    assign acc_stall   = verdict.stall;
    assign acc_deny    = verdict.deny;
    assign dsi_cause   = cause_q;

endmodule

// File: rtl/rmattr_chk.sv
module rmattr_chk (
    input logic       clk,
    input logic       rst,
    input logic       acc_valid,
    input logic [1:0] acc_kind,
    input logic       acc_spec,
    input logic       acc_virt,
    input logic       tlb_guard,
    input logic       tlb_little,
    input logic       prior_done,
    input logic       out_guard,
    input logic       byte_le,
    input logic       acc_grant,
    input logic       acc_stall,
    input logic       acc_deny,
    input logic       dsi_valid,
    input logic [1:0] dsi_cause
);

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        acc_valid |-> ($countones({acc_grant, acc_stall, acc_deny}) == 1)); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !(acc_grant || acc_stall || acc_deny)); // R11

    AST_GUARD_SPEC_DENY: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && out_guard && (acc_spec || acc_kind == 2'd3)) |-> acc_deny); // R5

    AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
        acc_stall |-> (acc_kind == 2'd0 && out_guard && !prior_done)); // R6

    AST_FAULT_AFTER_STORE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_kind == 2'd2 && acc_deny && !out_guard) |=> (dsi_valid && dsi_cause == 2'd1)); // R7

    AST_FAULT_SOURCE: assert property (@(posedge clk) disable iff (rst)
        dsi_valid |-> $past(acc_valid && acc_kind == 2'd2 && acc_deny)); // R7

    AST_VIRT_PASS: assert property (@(posedge clk) disable iff (rst)
        acc_virt |-> (out_guard == tlb_guard && byte_le == tlb_little)); // R4

endmodule

bind rmattr_unit rmattr_chk u_chk (.*);

// File: tb/sim_rmattr_unit.sv
`timescale 1ns/1ps
module sim_rmattr_unit;

    typedef struct {
        string tag;
        logic  grant, stall, deny, exc;
        logic  g, u, le, nc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_sel = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_spec = 1'b0, acc_virt = 1'b0;
    logic        tlb_guard = 1'b0, tlb_user = 1'b0, tlb_little = 1'b0, tlb_nocache = 1'b0;
    logic        prior_done = 1'b0;
    logic        out_guard, out_user, out_nocache, byte_le;
    logic        acc_grant, acc_stall, acc_deny, dsi_valid;
    logic [1:0]  dsi_cause;

    int checks = 0;
    int errors = 0;
    exp_t q[$];
    logic [31:0] mg = '0, mu = '0, me = '0, mn = '0;
    bit mx = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    rmattr_unit u0 (.*);

    task automatic chk(string tag, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got %b exp %b", tag, what, got, exp);
        end
    endtask

    // Driver: drive one cycle, push the expected result, then update the model.
    task automatic step(bit wv, logic [2:0] ws, logic [31:0] wd,
                        bit av, logic [31:0] a, logic [1:0] k, bit sp, bit vm,
                        logic [3:0] tlb, bit pd, string tag);
        exp_t e;
        logic [4:0] idx;
        logic specx;
        @(negedge clk);
        cfg_wr_en = wv; cfg_wr_sel = ws; cfg_wr_data = wd;
        acc_valid = av; acc_addr = a; acc_kind = k; acc_spec = sp; acc_virt = vm;
        {tlb_guard, tlb_user, tlb_little, tlb_nocache} = tlb;
        prior_done = pd;
        idx = a[31:27];
        e.tag = tag;
        if (vm) {e.g, e.u, e.le, e.nc} = tlb;
        else begin
            e.g = mg[idx]; e.u = mu[idx]; e.le = me[idx]; e.nc = mn[idx];
        end
        e.grant = 0; e.stall = 0; e.deny = 0; e.exc = 0;
        specx = sp || (k == 2'd3);
        if (av) begin
            if (e.g && specx) e.deny = 1;
            else if (k == 2'd0 && e.g && !pd) e.stall = 1;
            else if (k == 2'd2 && e.u && mx) begin e.deny = 1; e.exc = 1; end
            else e.grant = 1;
        end
        q.push_back(e);
        if (wv) begin
            case (ws)
                3'd0: mg = wd;
                3'd1: mu = wd;
                3'd2: me = wd;
                3'd3: mn = wd;
                3'd4: mx = wd[0];
                default: ;
            endcase
        end
    endtask

    task automatic wr(logic [2:0] ws, logic [31:0] wd, string tag);
        step(1, ws, wd, 0, 32'h0, 2'd1, 0, 0, 4'h0, 0, tag);
    endtask

    task automatic acc(logic [31:0] a, logic [1:0] k, bit sp, bit pd, string tag);
        step(0, 3'd0, 32'h0, 1, a, k, sp, 0, 4'h0, pd, tag);
    endtask

    task automatic vacc(logic [31:0] a, logic [1:0] k, bit sp, logic [3:0] tlb, string tag);
        step(0, 3'd0, 32'h0, 1, a, k, sp, 1, tlb, 1, tag);
    endtask

    // Monitor: pop one expected item per cycle; the fault pulse belongs to the previous item.
    initial begin
        exp_t e;
        logic prev_exc;
        string prev_tag;
        prev_exc = 0;
        prev_tag = "R1 reset";
        wait (!rst);
        forever begin
            @(negedge clk);
            #1;
            chk(prev_tag, "dsi_valid", dsi_valid, prev_exc);
            if (prev_exc) chk(prev_tag, "dsi_cause", dsi_cause[0], 1'b1);
            if (q.size() > 0) begin
                e = q.pop_front();
                chk(e.tag, "grant", acc_grant, e.grant);
                chk(e.tag, "stall", acc_stall, e.stall);
                chk(e.tag, "deny", acc_deny, e.deny);
                chk(e.tag, "guard", out_guard, e.g);
                chk(e.tag, "user", out_user, e.u);
                chk(e.tag, "byte_le", byte_le, e.le);
                chk(e.tag, "nocache", out_nocache, e.nc);
                prev_exc = e.exc;
                prev_tag = e.tag;
            end else begin
                prev_exc = 0;
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        acc(32'hFFFF_FFFF, 2'd1, 1, 0, "R1 reset spec load top");
        acc(32'h0000_0000, 2'd2, 0, 0, "R1 reset store bottom");
        acc(32'h4000_0000, 2'd0, 0, 0, "R1 reset fetch");
        // R10: write and access in the same cycle, then the next cycle
        step(1, 3'd0, 32'h0000_0008, 1, 32'h1800_0000, 2'd1, 1, 0, 4'h0, 0, "R10 same-cycle old value");
        acc(32'h1800_0000, 2'd1, 1, 0, "R10 next-cycle new value R5");
        // R2: region boundaries
        acc(32'h1FFF_FFFF, 2'd1, 1, 0, "R2 top of region 3");
        acc(32'h2000_0000, 2'd1, 1, 0, "R2 first byte of region 4");
        acc(32'h17FF_FFFF, 2'd1, 1, 0, "R2 last byte of region 2");
        // R5: prefetch, spec fetch, nonspec load
        acc(32'h1900_0000, 2'd3, 0, 1, "R5 prefetch guarded");
        acc(32'h1900_0000, 2'd0, 1, 1, "R5 spec fetch guarded");
        acc(32'h1900_0000, 2'd1, 0, 0, "R5 demand load guarded");
        acc(32'h3000_0000, 2'd3, 0, 0, "R5 prefetch unguarded");
        // R6: guarded fetch waits for completion
        acc(32'h1A00_0000, 2'd0, 0, 0, "R6 fetch stall 1");
        acc(32'h1A00_0000, 2'd0, 0, 0, "R6 fetch stall 2");
        acc(32'h1A00_0000, 2'd0, 0, 1, "R6 fetch released");
        // R7: user store fault
        wr(3'd1, 32'h8000_0001, "R7 write user plane");
        wr(3'd4, 32'h0000_0001, "R7 enable fault");
        acc(32'hF800_0000, 2'd2, 0, 0, "R7 store fault");
        acc(32'hF800_0000, 2'd1, 0, 0, "R8 load after store no fault");
        acc(32'h0000_0010, 2'd2, 0, 0, "R7 back-to-back store A");
        acc(32'hFFFF_FFF0, 2'd2, 0, 0, "R7 back-to-back store B");
        acc(32'h0000_0010, 2'd0, 0, 0, "R8 fetch user region");
        acc(32'h0800_0000, 2'd2, 0, 0, "R7 store non-user region");
        // R8: enable off
        step(1, 3'd4, 32'h0, 1, 32'hF800_0000, 2'd2, 0, 0, 4'h0, 0, "R8 store while disabling");
        acc(32'hF800_0000, 2'd2, 0, 0, "R8 store disabled");
        // R9 and R3: byte order and cache-inhibit planes
        wr(3'd2, 32'h0000_0001, "R9 order plane");
        wr(3'd3, 32'h4000_0000, "R3 nocache plane");
        acc(32'h0000_0100, 2'd1, 0, 0, "R9 little-endian region 0");
        acc(32'h0800_0100, 2'd1, 0, 0, "R9 big-endian region 1");
        acc(32'hF000_0000, 2'd1, 0, 0, "R3 nocache region 30");
        // R4: virtual mode overrides the planes
        vacc(32'h2000_0000, 2'd1, 1, 4'b1000, "R4 tlb guard denies");
        vacc(32'h1800_0000, 2'd1, 1, 4'b0011, "R4 tlb unguarded over guarded plane");
        vacc(32'h0000_0000, 2'd1, 0, 4'b0000, "R4 tlb big-endian over little plane");
        step(1, 3'd4, 32'h1, 0, 32'h0, 2'd1, 0, 0, 4'h0, 0, "R7 re-enable");
        vacc(32'h0000_0000, 2'd2, 0, 4'b0100, "R4 tlb user store faults R7");
        vacc(32'hF800_0000, 2'd2, 0, 4'b0000, "R4 tlb non-user store");
        // R11: idle cycles
        step(0, 3'd0, 32'h0, 0, 32'h1800_0000, 2'd0, 1, 0, 4'h0, 0, "R11 idle guarded");
        step(0, 3'd0, 32'h0, 0, 32'hF800_0000, 2'd2, 0, 0, 4'h0, 0, "R11 idle store");
        @(negedge clk);
        acc_valid = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule